// File: doc/BRIEF.md
# SPI Mode-Selectable Master

This block is a synchronous serial master that exchanges one word at a time with one of several peripherals, each wired to its own active-low select line. The host presents a transmit word, the index of the target peripheral, the clock polarity, the clock phase and a half-period divider, then pulses `start`. The block lowers the chosen select, drives the serial clock and the outgoing data line, samples the incoming data line, and at the end releases the select and pulses `done` with the received word on `rx_word`.

Polarity and phase are chosen per transfer, so all four clock modes are usable on one bus. Words go most significant bit first. Internally the outgoing and incoming bits share one shift register. Each bit shifted out makes room for one bit shifted in, so after a whole word the register holds what the peripheral sent. There is no acknowledgment, and the transfer always runs to completion.

A transfer accepted on clock edge T0 with an effective divider D (a programmed 0 counts as 1) has fixed timing. Serial clock edge k lands on edge T0 + k·D, for k = 1 to 2·WORD_W. The select is released and `done` is raised on edge T0 + (2·WORD_W+1)·D.

Top module: `spi_mode_master`

## Requirements
- R1: In reset and on the first cycle after it, all select lines are high, `busy` and `done` are low, and `sclk` and `mosi` are low. `mosi` stays low whenever no transfer is running.
- R2: While idle, `sclk` follows `cpol` with one cycle of delay: 0 gives a low idle level and 1 gives a high one.
- R3: From the cycle after `start` is accepted until the transfer ends, exactly the select line numbered `sel_idx` (bit `sel_idx` of `sel_n`) is low. All others stay high, and none is low while idle.
- R4: A transfer makes exactly 2·WORD_W toggles of `sclk`, spaced D system clocks apart. The first toggle comes D cycles after the select falls, and the select rises D cycles after the last toggle. A `half_div` of 0 behaves as 1.
- R5: With `cpha`=0, `mosi` carries the most significant transmit bit from the moment the select falls. It moves to the next bit on each trailing `sclk` edge, and `miso` is sampled on leading edges.
- R6: With `cpha`=1, `mosi` stays low until the first leading edge. It then presents the next bit on each leading edge, and `miso` is sampled on trailing edges.
- R7: Both directions are most significant bit first. The first bit sampled from `miso` ends up in bit WORD_W-1 of `rx_word`, which is valid while `done` is high.
- R8: `done` is a one-cycle pulse in the cycle in which `busy` has just fallen and every select is high. It comes whatever the peripheral drives on `miso`.
- R9: A `start` that arrives while `busy` is high is ignored. It does not change the select lines, the clock pattern, the outgoing bits or the received word, and the inputs latched at acceptance stay in force.
- R10: `busy` is high from the cycle after `start` is accepted through the last serial clock half-period, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request a transfer; taken only when idle |
| tx_word | input | WORD_W | Word to send, latched at acceptance |
| sel_idx | input | IDX_W | Index of the peripheral to select |
| cpol | input | 1 | Clock idle level |
| cpha | input | 1 | 0: sample on leading edge, 1: sample on trailing edge |
| half_div | input | DIV_W | System clocks per serial clock half-period (0 acts as 1) |
| miso | input | 1 | Serial data from the peripheral |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| rx_word | output | WORD_W | Received word |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the peripheral |
| sel_n | output | NUM_SEL | Active-low per-peripheral selects |

## Verification
The single-select assertion takes for granted that `sel_idx` is below NUM_SEL when a transfer is accepted. The stimulus only ever presents indices in that range, even for the stray start pulses injected during a transfer. The tick-spacing assertion assumes the divider latched at acceptance is not modified inside the counter. To stress that assumption, the stimulus changes `half_div`, `cpol` and `tx_word` mid-transfer. The stimulus also changes `cpol` only while idle or under a stray start, so that the idle-level assertion and the bench compare against the same polarity.

// File: rtl/spi_mode_pkg.sv
package spi_mode_pkg;

   typedef enum logic [0:0] {
      XF_IDLE = 1'b0,
      XF_RUN  = 1'b1
   } xf_state_t;

   // width needed to count from 0 to n inclusive
   function automatic int unsigned count_w(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n + 1);
   endfunction

endpackage

// File: rtl/spi_mode_tick.sv
module spi_mode_tick #(
   parameter int unsigned DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             run,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);

   logic [DIV_W-1:0] div_eff;
   logic [DIV_W-1:0] div_q;
   logic [DIV_W-1:0] cnt_q;

   assign div_eff = (div == '0) ? DIV_W'(1) : div;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         div_q <= DIV_W'(1);
         cnt_q <= '0;
      end else if (load) begin
         div_q <= div_eff;
         cnt_q <= div_eff - DIV_W'(1);
      end else if (run) begin
         cnt_q <= (cnt_q == '0) ? (div_q - DIV_W'(1)) : (cnt_q - DIV_W'(1));
      end
   end

   assign tick = run && (cnt_q == '0);

   // R4: ticks are never adjacent unless the half-period is one cycle
   a_r4_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && div_q != DIV_W'(1)) |=> !tick);

endmodule

// File: rtl/spi_mode_seldec.sv
module spi_mode_seldec #(
   parameter int unsigned NUM_SEL = 4,
   parameter int unsigned IDX_W   = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic               release_all,
   input  logic [IDX_W-1:0]   idx,
   output logic [NUM_SEL-1:0] sel_n
);

   logic [NUM_SEL-1:0] hit;

   for (genvar g = 0; g < NUM_SEL; g++) begin : g_hit
      assign hit[g] = (idx == IDX_W'(g));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sel_n <= '1;
      end else if (load) begin
         sel_n <= ~hit;
      end else if (release_all) begin
         sel_n <= '1;
      end
   end

   // R3: never more than one peripheral selected
   a_r3_at_most_one: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(~sel_n) <= 1);

endmodule

// File: rtl/spi_mode_master.sv
module spi_mode_master
   import spi_mode_pkg::*;
#(
   parameter int unsigned WORD_W  = 8,
   parameter int unsigned NUM_SEL = 4,
   parameter int unsigned DIV_W   = 8,
   localparam int unsigned IDX_W  = (NUM_SEL > 1) ? $clog2(NUM_SEL) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [WORD_W-1:0]  tx_word,
   input  logic [IDX_W-1:0]   sel_idx,
   input  logic               cpol,
   input  logic               cpha,
   input  logic [DIV_W-1:0]   half_div,
   input  logic               miso,
   output logic               busy,
   output logic               done,
   output logic [WORD_W-1:0]  rx_word,
   output logic               sclk,
   output logic               mosi,
   output logic [NUM_SEL-1:0] sel_n
);

   localparam int unsigned EDGES  = 2 * WORD_W;
   localparam int unsigned ECNT_W = count_w(EDGES);

   initial begin
      assert (WORD_W >= 2) else $fatal(1, "WORD_W must be at least 2");
      assert (NUM_SEL >= 1) else $fatal(1, "NUM_SEL must be at least 1");
      assert (DIV_W >= 1) else $fatal(1, "DIV_W must be at least 1");
   end

   xf_state_t          st_q;
   logic [ECNT_W-1:0]  ecnt_q;
   logic               cpha_q;
   logic               sclk_q;
   logic [WORD_W-1:0]  ring_q;
   logic               sbit_q;
   logic               oen_q;
   logic [WORD_W-1:0]  rx_q;
   logic               done_q;

   logic accept, tick, last_t, end_t, lead_t, trail_t, samp_t, shift_t;
   logic [WORD_W-1:0] ring_in;

   assign accept  = (st_q == XF_IDLE) && start;
   assign last_t  = (ecnt_q == ECNT_W'(EDGES));
   assign end_t   = tick && last_t;
   assign lead_t  = tick && !last_t && !ecnt_q[0];
   assign trail_t = tick && !last_t &&  ecnt_q[0];
   assign samp_t  = cpha_q ? trail_t : lead_t;
   assign shift_t = cpha_q ? ((lead_t && ecnt_q != '0) || end_t) : trail_t;
   assign ring_in = {ring_q[WORD_W-2:0], sbit_q};

   spi_mode_tick #(.DIV_W(DIV_W)) u_tick (
      .clk  (clk),
      .rst_n(rst_n),
      .load (accept),
      .run  (st_q == XF_RUN),
      .div  (half_div),
      .tick (tick)
   );

   spi_mode_seldec #(.NUM_SEL(NUM_SEL), .IDX_W(IDX_W)) u_sel (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (accept),
      .release_all(end_t),
      .idx        (sel_idx),
      .sel_n      (sel_n)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= XF_IDLE;
         ecnt_q <= '0;
         cpha_q <= 1'b0;
         sclk_q <= 1'b0;
         ring_q <= '0;
         sbit_q <= 1'b0;
         oen_q  <= 1'b0;
         rx_q   <= '0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (st_q == XF_IDLE) begin
            sclk_q <= cpol;
            if (accept) begin
               st_q   <= XF_RUN;
               ecnt_q <= '0;
               cpha_q <= cpha;
               ring_q <= tx_word;
               oen_q  <= !cpha;
            end
         end else begin
            if (tick) ecnt_q <= ecnt_q + ECNT_W'(1);
            if (tick && !last_t) sclk_q <= ~sclk_q;
            if (samp_t) sbit_q <= miso;
            if (shift_t) ring_q <= ring_in;
            if (cpha_q && lead_t && ecnt_q == '0) oen_q <= 1'b1;
            if (end_t) begin
               st_q   <= XF_IDLE;
               oen_q  <= 1'b0;
               done_q <= 1'b1;
               rx_q   <= cpha_q ? ring_in : ring_q;
            end
         end
      end
   end

   assign busy    = (st_q == XF_RUN);
   assign done    = done_q;
   assign rx_word = rx_q;
   assign sclk    = sclk_q;
   assign mosi    = oen_q & ring_q[WORD_W-1];

   logic past_ok;
   always_ff @(posedge clk) begin
      if (!rst_n) past_ok <= 1'b0;
      else        past_ok <= 1'b1;
   end

   // R2: idle clock level follows polarity input one cycle later
   a_r2_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && !busy && $past(!busy)) |-> (sclk == $past(cpol)));

   // R10 / R3: a running transfer selects exactly one peripheral (index assumed in range)
   a_r10_busy_selects_one: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> ($countones(~sel_n) == 1));

   // R9: selects cannot move while a transfer stays busy, whatever start does
   a_r9_sel_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && busy && $past(busy)) |-> $stable(sel_n));

   // R8: done is a single-cycle pulse with the bus released
   a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   a_r8_done_released: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && (&sel_n) && !mosi));

   // R1: data line quiet when idle
   a_r1_idle_mosi: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mosi);

endmodule

// File: tb/sim_spi_mode_master.sv
module sim_spi_mode_master;

   localparam int CLK_PERIOD = 10;
   localparam int W  = 8;
   localparam int NS = 4;
   localparam int DW = 8;
   localparam int IW = 2;
   localparam int EDGES = 2 * W;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [W-1:0]  tx_word = '0;
   logic [IW-1:0] sel_idx = '0;
   logic          cpol = 1'b0;
   logic          cpha = 1'b0;
   logic [DW-1:0] half_div = DW'(1);
   logic          miso;
   logic          busy, done, sclk, mosi;
   logic [W-1:0]  rx_word;
   logic [NS-1:0] sel_n;

   always #(CLK_PERIOD/2) clk = ~clk;

   spi_mode_master #(.WORD_W(W), .NUM_SEL(NS), .DIV_W(DW)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .tx_word(tx_word),
      .sel_idx(sel_idx), .cpol(cpol), .cpha(cpha), .half_div(half_div),
      .miso(miso), .busy(busy), .done(done), .rx_word(rx_word),
      .sclk(sclk), .mosi(mosi), .sel_n(sel_n)
   );

   int n_checks = 0;
   int n_errors = 0;

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
      end
   endtask

   // reference model: time since acceptance, latched settings
   bit          m_busy = 0;
   int          m_t = 0, m_endt = 0, m_div = 1, m_idx = 0;
   logic        m_cpol = 0, m_cpha = 0;
   logic [W-1:0] m_tx = '0;
   logic        cpol_seen = 0;
   bit          chk_on = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_busy = 0;
      end else begin
         if (m_busy && m_t == m_endt) m_busy = 0;
         else if (m_busy) m_t++;
         if (!m_busy && start) begin
            m_busy = 1;
            m_t    = 0;
            m_div  = (half_div == 0) ? 1 : int'(half_div);
            m_endt = (EDGES + 1) * m_div;
            m_idx  = int'(sel_idx);
            m_cpol = cpol;
            m_cpha = cpha;
            m_tx   = tx_word;
         end
      end
      cpol_seen = cpol;
   end

   // per-cycle comparison, half a period after the edge
   always @(negedge clk) begin
      if (chk_on) begin
         if (m_busy) begin
            int tg, k, l;
            logic [NS-1:0] es;
            tg = m_t / m_div;
            if (tg > EDGES) tg = EDGES;
            es = (m_t == m_endt) ? '1 : ~(NS'(1) << m_idx);
            chk("R10", "busy", 32'(busy), 32'(m_t < m_endt));
            chk("R8", "done", 32'(done), 32'(m_t == m_endt));
            chk("R3", "sel_n", 32'(sel_n), 32'(es));
            chk("R4", "sclk", 32'(sclk), 32'(m_cpol ^ logic'(tg % 2)));
            if (m_t == m_endt) begin
               chk("R8", "mosi", 32'(mosi), 32'(0));
            end else if (!m_cpha) begin
               k = tg / 2;
               if (k < W) chk("R5", "mosi", 32'(mosi), 32'(m_tx[W-1-k]));
            end else begin
               l = (tg + 1) / 2;
               if (l == 0) chk("R6", "mosi", 32'(mosi), 32'(0));
               else        chk("R6", "mosi", 32'(mosi), 32'(m_tx[W-l]));
            end
         end else begin
            chk("R10", "busy", 32'(busy), 32'(0));
            chk("R8", "done", 32'(done), 32'(0));
            chk("R3", "sel_n", 32'(sel_n), 32'({NS{1'b1}}));
            chk("R2", "sclk", 32'(sclk), 32'(cpol_seen));
            chk("R1", "mosi", 32'(mosi), 32'(0));
         end
      end
   end

   // behavioural peripheral
   logic [W-1:0] s_out = '0, s_in = '0;
   logic         s_prev = 0;
   assign miso = (sel_n[m_idx] == 1'b0) ? s_out[W-1] : 1'b0;

   always @(negedge clk) begin
      if (rst_n && sel_n[m_idx] == 1'b0 && sclk != s_prev) begin
         bit lead;
         lead = (sclk != m_cpol);
         if (lead != m_cpha) s_in = {s_in[W-2:0], mosi};
         if (!lead) s_out = s_out << 1;
      end
      s_prev = sclk;
   end

   task automatic summary();
      $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   endtask

   int cyc = 0;
   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog expired actual=hung expected=finished");
         summary();
      end
   end

   task automatic xfer(input logic [W-1:0] tx, input logic [W-1:0] sw,
                       input int idx, input logic pol, input logic pha,
                       input int div, input bit inj);
      @(negedge clk);
      s_out = sw; s_in = '0;
      tx_word = tx; sel_idx = IW'(idx); cpol = pol; cpha = pha; half_div = DW'(div);
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      if (inj) begin
         repeat (3) @(negedge clk);
         // R9: stray request with different settings while busy
         start = 1'b1; tx_word = ~tx; sel_idx = IW'(idx + 1); cpol = ~pol;
         half_div = DW'(div + 2);
         @(negedge clk);
         start = 1'b0;
      end
      while (done !== 1'b1) @(negedge clk);
      chk("R7", "rx_word", 32'(rx_word), 32'(sw));
      chk(pha ? "R6" : "R5", "peripheral got", 32'(s_in), 32'(tx));
      if (inj) chk("R9", "rx_word after stray start", 32'(rx_word), 32'(sw));
      @(negedge clk);
      cpol = pol;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R1", "sel_n in reset", 32'(sel_n), 32'({NS{1'b1}}));
      chk("R1", "busy in reset", 32'(busy), 32'(0));
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "sel_n after reset", 32'(sel_n), 32'({NS{1'b1}}));
      chk("R1", "done after reset", 32'(done), 32'(0));
      chk("R1", "sclk after reset", 32'(sclk), 32'(0));
      chk_on = 1;
      // R2: idle level follows polarity
      cpol = 1'b1;
      repeat (2) @(negedge clk);
      chk("R2", "idle sclk high", 32'(sclk), 32'(1));
      cpol = 1'b0;
      repeat (2) @(negedge clk);
      chk("R2", "idle sclk low", 32'(sclk), 32'(0));
      // all four modes, several dividers and patterns
      xfer(8'hA5, 8'h3C, 0, 1'b0, 1'b0, 1, 0);
      xfer(8'h96, 8'hC3, 1, 1'b0, 1'b1, 2, 0);
      xfer(8'h5A, 8'h81, 2, 1'b1, 1'b0, 3, 0);
      xfer(8'h01, 8'h7E, 3, 1'b1, 1'b1, 1, 0);
      // R4: divider 0 acts as 1
      xfer(8'hF0, 8'h0F, 1, 1'b0, 1'b0, 0, 0);
      // R8: completes with peripheral silent or stuck high
      xfer(8'hFF, 8'h00, 2, 1'b1, 1'b1, 2, 0);
      xfer(8'h00, 8'hFF, 0, 1'b0, 1'b1, 4, 0);
      // R9: stray start requests during transfers
      xfer(8'hC6, 8'h93, 1, 1'b0, 1'b0, 2, 1);
      xfer(8'h3B, 8'hE4, 2, 1'b1, 1'b1, 1, 1);
      repeat (4) @(negedge clk);
      summary();
   end

endmodule